// File: doc/BRIEF.md
# Prefetching Stream Bus Bridge

This bridge sits between a simple peripheral bus slave port and a decoder core. It has one shared write-data path and one shared read-data path. Inside, it splits bus traffic into two branches. The register branch reaches the core's control/status register array. The stream branch reaches the core's output stream source, which offers words with a valid/pull handshake in the style of a FIFO.

The bridge does not wait for a stream read before it fetches. As soon as its stream holding register is empty, it raises its pull signal toward the stream source and captures the next word. A bus read of the stream address therefore completes in the cycle it is presented. In the same cycle the bridge pulls the following word.

Register reads pass through a second holding register and take one wait cycle. Because that register is separate, a register read never touches a stream word that has already been prefetched. Writes to register addresses go straight to the register array. Writes to the stream address are dropped and answered with an error flag.

Top module: `stream_bridge`

## Requirements
- R1: After a synchronous reset with no stream word offered, `strm_pull` is 1, `bus_ready` is 0 while `bus_sel` is 0, and `bus_err` is 0.
- R2: While the stream holding register is empty, `strm_pull` is 1 with no bus request pending. A word offered with `strm_valid` is captured at the next clock edge. After that `strm_pull` stays 0 until the word is consumed, so exactly one word leaves the source.
- R3: A read (`bus_sel`=1, `bus_wr`=0) of address `STREAM_ADDR` (default all ones) completes with `bus_ready`=1 in the cycle it is presented when a word is held. `bus_rdata` then equals that held word.
- R4: A stream read that finds the holding register empty keeps `bus_ready` at 0 until a word arrives. It completes in the cycle after the source's `strm_valid` and the bridge's `strm_pull` were both 1, and it returns that word.
- R5: In the cycle a held word is consumed by a stream read, `strm_pull` is 1. Consecutive stream reads with a source that always has data complete with no wait cycles and return words in source order.
- R6: A read of any address other than `STREAM_ADDR` has `bus_ready`=0 in its first cycle and 1 in its second. It returns the value `reg_rdata` had in the first cycle.
- R7: A register read leaves the stream holding register untouched: `strm_pull` stays 0 while a word is held, and the next stream read returns the same word with no wait.
- R8: A write to a register address completes in the same cycle with `bus_err`=0. In that cycle `reg_we`=1, `reg_addr`=`bus_addr` and `reg_wdata`=`bus_wdata`.
- R9: A write to `STREAM_ADDR` completes in the same cycle with `bus_err`=1 and `reg_we`=0, and it leaves the held stream word in place.
- R10: Reset drops any held stream word. The first stream read after reset returns the next word the source provides after reset, not the word that was held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus request present; held until `bus_ready` |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | DW | Shared write-data path |
| bus_rdata | output | DW | Shared read-data path |
| bus_ready | output | 1 | Transfer completes this cycle |
| bus_err | output | 1 | Error response (write to stream address) |
| reg_we | output | 1 | Register array write strobe |
| reg_addr | output | AW | Register array address |
| reg_wdata | output | DW | Register array write data |
| reg_rdata | input | DW | Register array read data for `reg_addr` (combinational) |
| strm_valid | input | 1 | Stream source has a word |
| strm_data | input | DW | Stream source word |
| strm_pull | output | 1 | Buffer control: take the offered word this cycle |

## Verification
The bench gives a register read while a stream word is held. A bridge that shared one holding register would return the wrong stream word afterwards, or pull a fresh one. A stream read is made against an empty holder with the source idle for several cycles; a bridge that answered early would hand back stale data with the wrong wait count. Back-to-back stream reads catch a bridge that refills only after consumption and so inserts a wait cycle. Reset while a word is held catches a bridge that keeps the stale word, and a write to the stream address catches one that either reaches the register array or disturbs the holder.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_REG_RD,
    ACC_REG_WR,
    ACC_STR_RD,
    ACC_STR_WR
  } acc_e;

  // Classify one bus cycle from its request, direction and stream-address hit.
  function automatic acc_e classify(input logic sel, input logic wr, input logic hit);
    if (!sel)     return ACC_IDLE;
    else if (hit) return wr ? ACC_STR_WR : ACC_STR_RD;
    else          return wr ? ACC_REG_WR : ACC_REG_RD;
  endfunction

  // Occupancy of a one-word holder after a possible load and a possible take.
  function automatic logic hold_next(input logic valid, input logic load, input logic take);
    return load | (valid & ~take);
  endfunction

endpackage

// File: rtl/sbb_decode.sv
module sbb_decode
  import sbb_pkg::*;
#(
  parameter int unsigned          AW          = 4,
  parameter logic [AW-1:0]        STREAM_ADDR = '1
) (
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output acc_e          acc
);
  logic hit_stream;
  assign hit_stream = (addr == STREAM_ADDR);
  assign acc        = classify(sel, wr, hit_stream);
endmodule

// File: rtl/sbb_stream_hold.sv
module sbb_stream_hold
  import sbb_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          consume,
  input  logic          strm_valid,
  input  logic [DW-1:0] strm_data,
  output logic          strm_pull,
  output logic          hold_valid,
  output logic [DW-1:0] hold_data
);
  logic load;

  // Refill whenever empty, or in the same cycle the held word leaves.
  assign strm_pull = ~hold_valid | consume;
  assign load      = strm_pull & strm_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
    end else begin
      hold_valid <= hold_next(hold_valid, load, consume);
    end
  end

  always_ff @(posedge clk) begin
    if (load) hold_data <= strm_data;
  end

  p_pull_when_empty_r2: assert property (@(posedge clk) disable iff (rst)
    !hold_valid |-> strm_pull);

  p_refill_on_take_r5: assert property (@(posedge clk) disable iff (rst)
    consume |-> strm_pull);

  p_no_take_when_empty_r4: assert property (@(posedge clk) disable iff (rst)
    consume |-> hold_valid);
endmodule

// File: rtl/sbb_reg_hold.sv
module sbb_reg_hold #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic [DW-1:0] reg_rdata,
  output logic          pend,
  output logic [DW-1:0] hold_data
);
  logic capture;

  // First cycle of a register read captures; second cycle completes it.
  assign capture = rd_req & ~pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= capture;
  end

  always_ff @(posedge clk) begin
    if (capture) hold_data <= reg_rdata;
  end

  p_capture_then_serve_r6: assert property (@(posedge clk) disable iff (rst)
    capture |=> pend);

  p_pend_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    pend |=> !pend);
endmodule

// File: rtl/stream_bridge.sv
module stream_bridge
  import sbb_pkg::*;
#(
  parameter int unsigned   AW          = 4,
  parameter int unsigned   DW          = 32,
  parameter logic [AW-1:0] STREAM_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ready,
  output logic          bus_err,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  input  logic          strm_valid,
  input  logic [DW-1:0] strm_data,
  output logic          strm_pull
);
  acc_e          acc;
  logic          is_str_rd, is_str_wr, is_reg_rd, is_reg_wr;
  logic          consume;
  logic          s_valid;
  logic [DW-1:0] s_data;
  logic          r_pend;
  logic [DW-1:0] r_data;

  sbb_decode #(.AW(AW), .STREAM_ADDR(STREAM_ADDR)) u_dec (
    .sel (bus_sel),
    .wr  (bus_wr),
    .addr(bus_addr),
    .acc (acc)
  );

  assign is_str_rd = (acc == ACC_STR_RD);
  assign is_str_wr = (acc == ACC_STR_WR);
  assign is_reg_rd = (acc == ACC_REG_RD);
  assign is_reg_wr = (acc == ACC_REG_WR);
  assign consume   = is_str_rd & s_valid;

  sbb_stream_hold #(.DW(DW)) u_strm (
    .clk       (clk),
    .rst       (rst),
    .consume   (consume),
    .strm_valid(strm_valid),
    .strm_data (strm_data),
    .strm_pull (strm_pull),
    .hold_valid(s_valid),
    .hold_data (s_data)
  );

  sbb_reg_hold #(.DW(DW)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (is_reg_rd),
    .reg_rdata(reg_rdata),
    .pend     (r_pend),
    .hold_data(r_data)
  );

  assign reg_we    = is_reg_wr;
  assign reg_addr  = bus_addr;
  assign reg_wdata = bus_wdata;

  assign bus_ready = consume | (is_reg_rd & r_pend) | is_reg_wr | is_str_wr;
  assign bus_err   = is_str_wr;
  assign bus_rdata = is_str_rd ? s_data : r_data;

  p_zero_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (is_str_rd && s_valid) |-> bus_ready);

  p_wait_when_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (is_str_rd && !s_valid) |-> !bus_ready);

  p_reg_keeps_stream_r7: assert property (@(posedge clk) disable iff (rst)
    (is_reg_rd && s_valid) |=> (s_valid && $stable(s_data)));

  p_reg_write_r8: assert property (@(posedge clk) disable iff (rst)
    is_reg_wr |-> (bus_ready && !bus_err));

  p_stream_write_r9: assert property (@(posedge clk) disable iff (rst)
    is_str_wr |-> (bus_err && !reg_we && bus_ready));

  p_stream_write_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (is_str_wr && s_valid) |=> (s_valid && $stable(s_data)));
endmodule

// File: tb/stream_bridge_test.sv
module stream_bridge_test;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [AW-1:0] SADDR = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_ready, bus_err, reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          strm_valid, strm_pull;
  logic [DW-1:0] strm_data;

  // Core models: register array and an in-order word source.
  logic [DW-1:0] regs [16];
  int            src_ptr = 0;
  logic          src_en = 1'b0;
  int            n_chk = 0, n_bad = 0;
  int            exp_idx = 0;
  logic          done = 1'b0;

  function automatic logic [DW-1:0] word(input int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  assign reg_rdata  = regs[reg_addr];
  assign strm_valid = src_en;
  assign strm_data  = word(src_ptr);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (strm_valid && strm_pull) src_ptr <= src_ptr + 1;
    if (reg_we) regs[reg_addr] <= reg_wdata;
  end

  stream_bridge #(.AW(AW), .DW(DW), .STREAM_ADDR(SADDR)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .strm_valid(strm_valid), .strm_data(strm_data), .strm_pull(strm_pull)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int waits,
                         output logic pull_seen);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    waits = 0; pull_seen = 1'b0;
    forever begin
      #1;
      pull_seen = pull_seen | strm_pull;
      if (bus_ready) begin d = bus_rdata; break; end
      waits++;
      if (waits > 50) begin d = 'x; break; end
      @(negedge clk);
    end
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic rdy, output logic err, output logic we);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1; rdy = bus_ready; err = bus_err; we = reg_we;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 pull after reset", DW'(strm_pull), 1);
    chk("R1 ready idle", DW'(bus_ready), 0);
    chk("R1 err idle", DW'(bus_err), 0);
  endtask

  task automatic t_prefetch;
    @(negedge clk); src_en = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk("R2 pull low once held", DW'(strm_pull), 0);
    chk("R2 exactly one word taken", DW'(src_ptr), 1);
  endtask

  task automatic t_stream_hit;
    logic [DW-1:0] d; int w; logic p;
    do_read(SADDR, d, w, p);
    chk("R3 no wait", DW'(w), 0);
    chk("R3 data", d, word(exp_idx)); exp_idx++;
  endtask

  task automatic t_b2b;
    logic [DW-1:0] d0, d1; logic r0, r1, p0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = SADDR;
    #1; r0 = bus_ready; d0 = bus_rdata; p0 = strm_pull;
    @(negedge clk); #1; r1 = bus_ready; d1 = bus_rdata;
    @(posedge clk); #1; bus_sel = 1'b0;
    chk("R5 pull while consuming", DW'(p0), 1);
    chk("R5 first ready", DW'(r0), 1);
    chk("R5 first data", d0, word(exp_idx)); exp_idx++;
    chk("R5 second ready", DW'(r1), 1);
    chk("R5 second data", d1, word(exp_idx)); exp_idx++;
  endtask

  task automatic t_reg_write;
    logic r, e, w;
    do_write(4'h3, 32'hDEAD_BEEF, r, e, w);
    chk("R8 ready", DW'(r), 1);
    chk("R8 err", DW'(e), 0);
    chk("R8 strobe", DW'(w), 1);
    chk("R8 array updated", regs[3], 32'hDEAD_BEEF);
  endtask

  task automatic t_reg_read;
    logic [DW-1:0] d; int w; logic p;
    do_read(4'h3, d, w, p);
    chk("R6 one wait", DW'(w), 1);
    chk("R6 data", d, 32'hDEAD_BEEF);
    do_read(4'h0, d, w, p);
    chk("R6 other reg data", d, regs[0]);
  endtask

  task automatic t_reg_keep;
    logic [DW-1:0] d; int w; logic p; int ptr0;
    @(negedge clk); src_en = 1'b0; ptr0 = src_ptr;
    do_read(4'h7, d, w, p);
    chk("R7 no pull during reg read", DW'(p), 0);
    chk("R7 reg data", d, regs[7]);
    do_read(SADDR, d, w, p);
    chk("R7 stream no wait", DW'(w), 0);
    chk("R7 stream word kept", d, word(exp_idx)); exp_idx++;
    chk("R7 source untouched", DW'(src_ptr), DW'(ptr0));
  endtask

  task automatic t_stream_write;
    logic r, e, w; logic [DW-1:0] d; int wt; logic p; logic [DW-1:0] r15;
    @(negedge clk); src_en = 1'b1;
    @(negedge clk); r15 = regs[15];
    do_write(SADDR, 32'h1234_5678, r, e, w);
    chk("R9 ready", DW'(r), 1);
    chk("R9 err", DW'(e), 1);
    chk("R9 no strobe", DW'(w), 0);
    chk("R9 array unchanged", regs[15], r15);
    do_read(SADDR, d, wt, p);
    chk("R9 held word intact", d, word(exp_idx)); exp_idx++;
  endtask

  task automatic t_stream_empty;
    logic [DW-1:0] d; int w; logic p;
    @(negedge clk); src_en = 1'b0;
    do_read(SADDR, d, w, p);   // drain the held word
    chk("R4 drain data", d, word(exp_idx)); exp_idx++;
    fork
      do_read(SADDR, d, w, p);
      begin repeat (3) @(negedge clk); src_en = 1'b1; end
    join
    chk("R4 wait count", DW'(w), 3);
    chk("R4 data", d, word(exp_idx)); exp_idx++;
  endtask

  task automatic t_reset_clear;
    logic [DW-1:0] d; int w; logic p;
    @(negedge clk); src_en = 1'b1;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_idx++;                 // held word is discarded
    do_read(SADDR, d, w, p);
    chk("R10 stale word dropped", d, word(exp_idx)); exp_idx++;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h1111_0000 + 32'(i) * 32'h0000_0101;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_prefetch;
    t_stream_hit;
    t_b2b;
    t_reg_write;
    t_reg_read;
    t_reg_keep;
    t_stream_write;
    t_stream_empty;
    t_reset_clear;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule